// File: doc/BRIEF.md
# Register-Space Access Screen

This block is a purely combinational gate. It sits in front of two internal register spaces, a scratchpad bank and a set of interrupt-queue pointers, and decides whether a load or store that targets one of them may proceed. For every access it looks at three things: which space is addressed, the byte offset inside that space, and the privilege level the requester runs at. From these it produces exactly one verdict. The access is either allowed, rejected with an illegal-address fault, or rejected with a privileged-action fault.

When the verdict is a fault, the block also raises a capture strobe for the fault-status logic. Alongside the strobe it presents the record to store: the offset, the direction of the access, a side-effect flag and the space code. The register storage and the fault-status register are separate blocks. Accesses to any space code other than the two screened ones are allowed without checking.

Top module: `asr_access_screen`

## Requirements
- R1: For every input combination exactly one of `allow_o`, `flt_addr_o` and `flt_priv_o` is high.
- R2: In scratch space (space code 2'b01), an offset above 0x38 raises the address fault at every privilege level.
- R3: In scratch space, offsets 0x20 to 0x2F raise the address fault unless the level is hypervisor (level code 2'b10). At hypervisor level they are allowed.
- R4: In scratch space, offsets 0x00 to 0x1F and 0x30 to 0x38 are allowed at every level.
- R5: In queue space (space code 2'b10), a user-level access (level code 2'b00) raises the privileged-action fault whatever its offset. The privilege check takes priority over every address check.
- R6: In queue space, a privileged-level access (level code 2'b01) whose offset has a nonzero value in bits [3:0] raises the address fault.
- R7: In queue space, an access above the user level with an offset below 0x3C0 or above 0x3F8 raises the address fault.
- R8: In queue space, offsets 0x3C0 to 0x3F8 are allowed at hypervisor level for any alignment. At privileged level they are allowed when bits [3:0] are zero.
- R9: Space codes 2'b00 and 2'b11 are allowed for any offset and level.
- R10: `cap_strobe_o` is high exactly when a fault is raised. While it is high, the capture outputs carry the offset, the write flag, a side-effect flag of 1 and the space code. While it is low, all capture outputs are zero.
- R11: Level code 2'b11 is treated as user level in both screened spaces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| space_i | input | 2 | Target register space code |
| offset_i | input | OFS_W (12) | Byte offset inside the space |
| level_i | input | 2 | Requester privilege level code |
| write_i | input | 1 | 1 for a store, 0 for a load |
| allow_o | output | 1 | Access may proceed |
| flt_addr_o | output | 1 | Illegal-address fault |
| flt_priv_o | output | 1 | Privileged-action fault |
| cap_strobe_o | output | 1 | Fault-status capture request |
| cap_offset_o | output | OFS_W (12) | Offset to record |
| cap_write_o | output | 1 | Direction to record |
| cap_side_eff_o | output | 1 | Side-effect flag to record |
| cap_space_o | output | 2 | Space code to record |

## Verification
The block holds no state, so any fault in its logic shows up at the ports on the very access that exercises it. Such a fault would be a wrong range bound, a level decoded the wrong way, or a priority inverted between the privilege and address checks. The damage takes one of two forms. A verdict may go to the wrong output, or the capture record may carry a stale or missing field. Since the design holds no memory, the bench compares every vector with a model written from the requirements. It focuses on the offsets one step either side of each bound, and on the levels where the queue alignment rule switches on or off.

// File: rtl/asr_pkg.sv
package asr_pkg;

    typedef enum logic [1:0] {
        SPC_OTHER_LO = 2'b00,
        SPC_SCRATCH  = 2'b01,
        SPC_QUEUE    = 2'b10,
        SPC_OTHER_HI = 2'b11
    } space_e;

    typedef enum logic [1:0] {
        LVL_USER  = 2'b00,
        LVL_PRIV  = 2'b01,
        LVL_HYPER = 2'b10,
        LVL_RSVD  = 2'b11
    } level_e;

    // Outcome of one rule unit
    typedef struct packed {
        logic bad_addr;
        logic bad_priv;
    } verdict_t;

    localparam verdict_t VERDICT_OK = '{bad_addr: 1'b0, bad_priv: 1'b0};

    function automatic logic lvl_is_hyper(input level_e lvl);
        return lvl == LVL_HYPER;
    endfunction

    // Privileged or hypervisor; reserved code counts as user
    function automatic logic lvl_above_user(input level_e lvl);
        return (lvl == LVL_PRIV) || (lvl == LVL_HYPER);
    endfunction

endpackage

// File: rtl/asr_scratch_rule.sv
module asr_scratch_rule
    import asr_pkg::*;
#(
    parameter int OFS_W     = 12,
    parameter int TOP_OFS   = 'h38,
    parameter int HV_LO_OFS = 'h20,
    parameter int HV_HI_OFS = 'h2F
) (
    input  logic [OFS_W-1:0] offset_i,
    input  level_e           level_i,
    output verdict_t         verdict_o
);
    localparam logic [OFS_W-1:0] TOP_L   = OFS_W'(TOP_OFS);
    localparam logic [OFS_W-1:0] HV_LO_L = OFS_W'(HV_LO_OFS);
    localparam logic [OFS_W-1:0] HV_HI_L = OFS_W'(HV_HI_OFS);

    logic beyond_top;
    logic in_hv_window;

    always_comb begin
        beyond_top   = offset_i > TOP_L;
        in_hv_window = (offset_i >= HV_LO_L) && (offset_i <= HV_HI_L);
        verdict_o          = VERDICT_OK;
        verdict_o.bad_addr = beyond_top || (in_hv_window && !lvl_is_hyper(level_i));
    end

endmodule

// File: rtl/asr_queue_rule.sv
module asr_queue_rule
    import asr_pkg::*;
#(
    parameter int OFS_W      = 12,
    parameter int LO_OFS     = 'h3C0,
    parameter int HI_OFS     = 'h3F8,
    parameter int ALIGN_BITS = 4
) (
    input  logic [OFS_W-1:0] offset_i,
    input  level_e           level_i,
    output verdict_t         verdict_o
);
    localparam logic [OFS_W-1:0] LO_L = OFS_W'(LO_OFS);
    localparam logic [OFS_W-1:0] HI_L = OFS_W'(HI_OFS);

    logic misaligned;
    logic out_of_window;

    generate
        if (ALIGN_BITS > 0) begin : g_align
            assign misaligned = |offset_i[ALIGN_BITS-1:0];
        end else begin : g_noalign
            assign misaligned = 1'b0;
        end
    endgenerate

    always_comb begin
        out_of_window = (offset_i < LO_L) || (offset_i > HI_L);
        verdict_o     = VERDICT_OK;
        if (!lvl_above_user(level_i)) begin
            // privilege failure outranks any address failure
            verdict_o.bad_priv = 1'b1;
        end else begin
            verdict_o.bad_addr = out_of_window ||
                                 (misaligned && !lvl_is_hyper(level_i));
        end
    end

endmodule

// File: rtl/asr_fault_merge.sv
module asr_fault_merge
    import asr_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  space_e           space_i,
    input  verdict_t         scr_v_i,
    input  verdict_t         que_v_i,
    input  logic [OFS_W-1:0] offset_i,
    input  logic             write_i,
    output logic             allow_o,
    output logic             flt_addr_o,
    output logic             flt_priv_o,
    output logic             cap_strobe_o,
    output logic [OFS_W-1:0] cap_offset_o,
    output logic             cap_write_o,
    output logic             cap_side_eff_o,
    output logic [1:0]       cap_space_o
);
    verdict_t sel_v;
    logic     any_fault;

    always_comb begin
        unique case (space_i)
            SPC_SCRATCH: sel_v = scr_v_i;
            SPC_QUEUE:   sel_v = que_v_i;
            default:     sel_v = VERDICT_OK;
        endcase

        flt_priv_o = sel_v.bad_priv;
        flt_addr_o = sel_v.bad_addr && !sel_v.bad_priv;
        any_fault  = sel_v.bad_priv || sel_v.bad_addr;
        allow_o    = !any_fault;

        cap_strobe_o   = any_fault;
        cap_offset_o   = any_fault ? offset_i : '0;
        cap_write_o    = any_fault && write_i;
        cap_side_eff_o = any_fault;
        cap_space_o    = any_fault ? space_i : 2'b00;
    end

endmodule

// File: rtl/asr_access_screen.sv
module asr_access_screen
    import asr_pkg::*;
#(
    parameter int OFS_W       = 12,
    parameter int SCR_TOP     = 'h38,
    parameter int SCR_HV_LO   = 'h20,
    parameter int SCR_HV_HI   = 'h2F,
    parameter int QUE_LO      = 'h3C0,
    parameter int QUE_HI      = 'h3F8,
    parameter int QUE_ALIGN   = 4
) (
    input  logic [1:0]       space_i,
    input  logic [OFS_W-1:0] offset_i,
    input  logic [1:0]       level_i,
    input  logic             write_i,
    output logic             allow_o,
    output logic             flt_addr_o,
    output logic             flt_priv_o,
    output logic             cap_strobe_o,
    output logic [OFS_W-1:0] cap_offset_o,
    output logic             cap_write_o,
    output logic             cap_side_eff_o,
    output logic [1:0]       cap_space_o
);
    space_e   space_q;
    level_e   level_q;
    verdict_t scr_v;
    verdict_t que_v;

    assign space_q = space_e'(space_i);
    assign level_q = level_e'(level_i);

    asr_scratch_rule #(
        .OFS_W    (OFS_W),
        .TOP_OFS  (SCR_TOP),
        .HV_LO_OFS(SCR_HV_LO),
        .HV_HI_OFS(SCR_HV_HI)
    ) i_scratch (
        .offset_i (offset_i),
        .level_i  (level_q),
        .verdict_o(scr_v)
    );

    asr_queue_rule #(
        .OFS_W     (OFS_W),
        .LO_OFS    (QUE_LO),
        .HI_OFS    (QUE_HI),
        .ALIGN_BITS(QUE_ALIGN)
    ) i_queue (
        .offset_i (offset_i),
        .level_i  (level_q),
        .verdict_o(que_v)
    );

    asr_fault_merge #(
        .OFS_W(OFS_W)
    ) i_merge (
        .space_i       (space_q),
        .scr_v_i       (scr_v),
        .que_v_i       (que_v),
        .offset_i      (offset_i),
        .write_i       (write_i),
        .allow_o       (allow_o),
        .flt_addr_o    (flt_addr_o),
        .flt_priv_o    (flt_priv_o),
        .cap_strobe_o  (cap_strobe_o),
        .cap_offset_o  (cap_offset_o),
        .cap_write_o   (cap_write_o),
        .cap_side_eff_o(cap_side_eff_o),
        .cap_space_o   (cap_space_o)
    );

endmodule

// File: rtl/asr_access_screen_chk.sv
module asr_access_screen_chk #(
    parameter int OFS_W = 12
) (
    input logic [1:0]       space_i,
    input logic [OFS_W-1:0] offset_i,
    input logic [1:0]       level_i,
    input logic             write_i,
    input logic             allow_o,
    input logic             flt_addr_o,
    input logic             flt_priv_o,
    input logic             cap_strobe_o,
    input logic [OFS_W-1:0] cap_offset_o,
    input logic             cap_write_o,
    input logic             cap_side_eff_o,
    input logic [1:0]       cap_space_o
);
    always_comb begin
        AST_ONE_OUTCOME: assert ($countones({allow_o, flt_addr_o, flt_priv_o}) == 1); // R1
        AST_STROBE_ON_FAULT: assert (cap_strobe_o == (flt_addr_o || flt_priv_o)); // R10
        AST_CAP_RECORD: assert (!cap_strobe_o || (cap_offset_o == offset_i && cap_write_o == write_i && cap_side_eff_o && cap_space_o == space_i)); // R10
        AST_CAP_QUIET: assert (cap_strobe_o || (cap_offset_o == '0 && !cap_write_o && !cap_side_eff_o && cap_space_o == 2'b00)); // R10
        AST_PRIV_FAULT_SCOPE: assert (!flt_priv_o || (space_i == 2'b10 && (level_i == 2'b00 || level_i == 2'b11))); // R5
        AST_OTHER_SPACE_PASS: assert (!(space_i == 2'b00 || space_i == 2'b11) || allow_o); // R9
        AST_SCRATCH_HIGH_FAULT: assert (!(space_i == 2'b01 && offset_i > OFS_W'('h38)) || flt_addr_o); // R2
        AST_QUEUE_HYPER_WINDOW: assert (!(space_i == 2'b10 && level_i == 2'b10 && offset_i >= OFS_W'('h3C0) && offset_i <= OFS_W'('h3F8)) || allow_o); // R8
    end
endmodule

bind asr_access_screen asr_access_screen_chk #(.OFS_W(OFS_W)) i_chk (
    .space_i       (space_i),
    .offset_i      (offset_i),
    .level_i       (level_i),
    .write_i       (write_i),
    .allow_o       (allow_o),
    .flt_addr_o    (flt_addr_o),
    .flt_priv_o    (flt_priv_o),
    .cap_strobe_o  (cap_strobe_o),
    .cap_offset_o  (cap_offset_o),
    .cap_write_o   (cap_write_o),
    .cap_side_eff_o(cap_side_eff_o),
    .cap_space_o   (cap_space_o)
);

// File: tb/test_asr_access_screen.sv
module test_asr_access_screen;
    localparam int OFS_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       space_i  = 2'b00;
    logic [OFS_W-1:0] offset_i = '0;
    logic [1:0]       level_i  = 2'b00;
    logic             write_i  = 1'b0;
    logic             allow_o, flt_addr_o, flt_priv_o, cap_strobe_o;
    logic [OFS_W-1:0] cap_offset_o;
    logic             cap_write_o, cap_side_eff_o;
    logic [1:0]       cap_space_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    asr_access_screen i_asr_access_screen (
        .space_i(space_i), .offset_i(offset_i), .level_i(level_i), .write_i(write_i),
        .allow_o(allow_o), .flt_addr_o(flt_addr_o), .flt_priv_o(flt_priv_o),
        .cap_strobe_o(cap_strobe_o), .cap_offset_o(cap_offset_o),
        .cap_write_o(cap_write_o), .cap_side_eff_o(cap_side_eff_o),
        .cap_space_o(cap_space_o)
    );

    // Model: returns {allow, addr fault, priv fault}
    function automatic logic [2:0] model(input logic [1:0] sp, input int off, input logic [1:0] lv);
        bit hyper = (lv == 2'b10);
        bit above = (lv == 2'b01) || (lv == 2'b10);
        if (sp == 2'b01) begin
            if (off > 'h38) return 3'b010;                          // R2
            if (off >= 'h20 && off <= 'h2F && !hyper) return 3'b010; // R3
            return 3'b100;                                           // R4
        end
        if (sp == 2'b10) begin
            if (!above) return 3'b001;                               // R5 R11
            if (off < 'h3C0 || off > 'h3F8) return 3'b010;           // R7
            if (!hyper && (off % 16) != 0) return 3'b010;            // R6
            return 3'b100;                                           // R8
        end
        return 3'b100;                                               // R9
    endfunction

    function automatic string req_of(input logic [1:0] sp, input int off, input logic [1:0] lv);
        if (sp == 2'b01) return (off > 'h38) ? "R2" : (off >= 'h20 && off <= 'h2F) ? "R3" : "R4";
        if (sp == 2'b10) begin
            if (lv == 2'b11) return "R11";
            if (lv == 2'b00) return "R5";
            if (off < 'h3C0 || off > 'h3F8) return "R7";
            return (lv == 2'b01 && (off % 16) != 0) ? "R6" : "R8";
        end
        return "R9";
    endfunction

    task automatic apply(input logic [1:0] sp, input int off, input logic [1:0] lv, input logic wr);
        logic [2:0] exp_v;
        logic [2:0] got_v;
        logic [OFS_W+4:0] exp_c;
        logic [OFS_W+4:0] got_c;
        bit flt;
        @(posedge clk);
        space_i  = sp;
        offset_i = OFS_W'(off);
        level_i  = lv;
        write_i  = wr;
        @(negedge clk);
        exp_v = model(sp, off, lv);
        got_v = {allow_o, flt_addr_o, flt_priv_o};
        tests++;
        if (got_v !== exp_v) begin
            fails++;
            $display("FAIL %s/R1 verdict sp=%0d off=%h lv=%0d: actual %b expected %b",
                     req_of(sp, off, lv), sp, off, lv, got_v, exp_v);
        end
        flt   = !exp_v[2];
        exp_c = flt ? {1'b1, OFS_W'(off), wr, 1'b1, sp} : '0;
        got_c = {cap_strobe_o, cap_offset_o, cap_write_o, cap_side_eff_o, cap_space_o};
        tests++;
        if (got_c !== exp_c) begin
            fails++;
            $display("FAIL R10 capture sp=%0d off=%h lv=%0d: actual %h expected %h",
                     sp, off, lv, got_c, exp_c);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset/idle state: other space, offset 0 -> allow, no capture (R9, R10)
        apply(2'b00, 0, 2'b00, 1'b0);
        // R2 / R3 / R4 scratch bounds
        apply(2'b01, 'h38, 2'b00, 1'b1);
        apply(2'b01, 'h39, 2'b10, 1'b1);
        apply(2'b01, 'hFFF, 2'b01, 1'b0);
        apply(2'b01, 'h1F, 2'b00, 1'b0);
        apply(2'b01, 'h20, 2'b01, 1'b1);
        apply(2'b01, 'h2F, 2'b00, 1'b0);
        apply(2'b01, 'h20, 2'b10, 1'b0);
        apply(2'b01, 'h2F, 2'b10, 1'b1);
        apply(2'b01, 'h30, 2'b00, 1'b0);
        apply(2'b01, 'h2F, 2'b11, 1'b1);
        // R5 priority, R11 reserved level
        apply(2'b10, 'h3C0, 2'b00, 1'b0);
        apply(2'b10, 'h005, 2'b00, 1'b1);
        apply(2'b10, 'h3C0, 2'b11, 1'b1);
        // R6 / R7 / R8 queue
        apply(2'b10, 'h3C8, 2'b01, 1'b1);
        apply(2'b10, 'h3C8, 2'b10, 1'b0);
        apply(2'b10, 'h3D0, 2'b01, 1'b0);
        apply(2'b10, 'h3BF, 2'b10, 1'b0);
        apply(2'b10, 'h3B0, 2'b01, 1'b1);
        apply(2'b10, 'h3F8, 2'b10, 1'b1);
        apply(2'b10, 'h3F9, 2'b10, 1'b0);
        apply(2'b10, 'h400, 2'b01, 1'b1);
        apply(2'b10, 'h3F0, 2'b01, 1'b0);
        // R9 other space
        apply(2'b11, 'hFFF, 2'b00, 1'b1);
        // random mix, fixed seed
        void'($urandom(32'h5EED_0042));
        for (int n = 0; n < 3000; n++) begin
            int sel = $urandom_range(0, 3);
            int off = (sel == 0) ? $urandom_range(0, 'hFFF) :
                      (sel == 1) ? $urandom_range(0, 'h40) :
                                   $urandom_range('h3B0, 'h408);
            apply(2'($urandom_range(0, 3)), off, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule